// File: doc/BRIEF.md
# Trace Address Delta Compressor

This block turns a stream of trace addresses into short messages on a 4-bit trace port. Each accepted address is compared with the last address sent of the same kind (branch source or window access). Only the low-order part that differs is sent: 1, 2, 4 or 8 nibbles. A message opens with one header nibble, marked by an active-low sync strobe. The payload nibbles follow, least significant first.

When an event arrives while a message is still leaving the port, the mode input decides what happens. In realtime mode the new event is thrown away and a sticky lost flag is raised. In non-realtime mode a stall request holds the CPU, which keeps the event on its inputs until the port is free.

Top module: `trc_delta_packer`

## Requirements
- R1: While reset is held and right after it, `tp_sync_n` is 1, `tp_data` is 0, `cpu_stall` is 0 and `lost_flag` is 0.
- R2: Each message starts with exactly one header cycle in which `tp_sync_n` is 0. The header nibble has bit 3 = kind (0 branch, 1 window), bit 2 = 0, and bits 1:0 = length code (0, 1, 2, 3 for 1, 2, 4, 8 payload nibbles).
- R3: The payload nibbles follow the header on consecutive cycles, least significant first, with `tp_sync_n` at 1. When the port is idle, `tp_data` is 0 and `tp_sync_n` is 1.
- R4: The length is chosen from the previous address sent of the same kind: 1 nibble if bits 31:4 are equal, 2 if bits 31:8 are equal, 4 if bits 31:16 are equal, and 8 otherwise.
- R5: The first message of each kind after reset carries all 8 nibbles.
- R6: Branch and window addresses keep separate histories. A message of one kind never shortens a message of the other kind.
- R7: In realtime mode (`rt_mode`=1), an event that arrives while the port is busy is discarded. The message in flight completes unchanged, `cpu_stall` stays 0, and `lost_flag` is 1 from the next cycle.
- R8: A one-cycle `lost_clr` pulse clears `lost_flag`. If a drop happens in the same cycle as the clear, the flag stays set.
- R9: In non-realtime mode (`rt_mode`=0), `cpu_stall` is 1 in every cycle in which `ev_valid` is 1 and the port is busy. The held event is sent in full once the port frees, so it stalls for 1+N cycles behind an N-nibble message.
- R10: An event on an idle port is taken at the clock edge. Its header appears in the next cycle, and the port stays busy for 1+N cycles.
- R11: A discarded event does not update the address history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Trace event present |
| ev_addr | input | 32 | Event address |
| ev_kind | input | 1 | 0 = branch source, 1 = window access |
| rt_mode | input | 1 | 1 = drop on busy, 0 = stall on busy |
| lost_clr | input | 1 | Host write that clears the lost flag |
| tp_data | output | 4 | Trace port nibble |
| tp_sync_n | output | 1 | Low during the header nibble |
| cpu_stall | output | 1 | Holds the CPU while an event waits |
| lost_flag | output | 1 | Sticky: an event was dropped |

## Verification
The bench sweeps every single-bit change between consecutive addresses, for both kinds, and adds random addresses. Each message is rebuilt from the previous address of its kind, so any misplaced match boundary, nibble order or history mix-up shows up as a wrong address. The bench also holds an event behind a full-length message in both modes:
- A design with an off-by-one busy window shows the wrong stall count.
- A design that lets a dropped event update the history shows up when the next same-kind message comes out too long.
- A design that gives the lost-flag clear priority over a drop in the same cycle loses the flag.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ADDR_W = 32;
  localparam int NIB_W  = 4;
  localparam int NKINDS = 2;
  localparam int CNT_W  = $clog2(ADDR_W / NIB_W + 1);

  // Length code from upper-bit agreement with the last address of the same kind
  function automatic logic [1:0] len_code(input logic [ADDR_W-1:0] cur,
                                          input logic [ADDR_W-1:0] prev,
                                          input logic seen);
    if (!seen)                               return 2'd3;
    if (cur[ADDR_W-1:4]  == prev[ADDR_W-1:4])  return 2'd0;
    if (cur[ADDR_W-1:8]  == prev[ADDR_W-1:8])  return 2'd1;
    if (cur[ADDR_W-1:16] == prev[ADDR_W-1:16]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [CNT_W-1:0] code_nibbles(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/trc_hist.sv
module trc_hist
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              kind,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] prev_addr,
  output logic              prev_seen
);
  logic [ADDR_W-1:0] last_q [NKINDS];
  logic [NKINDS-1:0] seen_q;

  for (genvar k = 0; k < NKINDS; k++) begin : g_kind
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q[k] <= '0;
        seen_q[k] <= 1'b0;
      end else if (wr_en && (int'(kind) == k)) begin
        last_q[k] <= wr_addr;
        seen_q[k] <= 1'b1;
      end
    end
  end

  assign prev_addr = last_q[kind];
  assign prev_seen = seen_q[kind];
endmodule

// File: rtl/trc_ser.sv
module trc_ser
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NIB_W-1:0]  hdr,
  input  logic [ADDR_W-1:0] payload,
  input  logic [CNT_W-1:0]  nibs,
  output logic [NIB_W-1:0]  data,
  output logic              sync_n,
  output logic              busy
);
  logic              hdr_phase;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] sh_q;
  logic [NIB_W-1:0]  hdr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_phase <= 1'b0;
      left_q    <= '0;
      sh_q      <= '0;
      hdr_q     <= '0;
    end else if (load) begin
      hdr_phase <= 1'b1;
      left_q    <= nibs;
      sh_q      <= payload;
      hdr_q     <= hdr;
    end else if (hdr_phase) begin
      hdr_phase <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      sh_q   <= sh_q >> NIB_W;
    end
  end

  always_comb begin
    if (hdr_phase)           data = hdr_q;
    else if (left_q != '0)   data = sh_q[NIB_W-1:0];
    else                     data = '0;
  end

  assign sync_n = ~hdr_phase;
  assign busy   = hdr_phase | (left_q != '0);
endmodule

// File: rtl/trc_delta_packer.sv
module trc_delta_packer
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_kind,
  input  logic              rt_mode,
  input  logic              lost_clr,
  output logic [NIB_W-1:0]  tp_data,
  output logic              tp_sync_n,
  output logic              cpu_stall,
  output logic              lost_flag
);
  logic              port_busy;
  logic              accept_evt;
  logic              drop_evt;
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_seen;
  logic [1:0]        code;
  logic [NIB_W-1:0]  hdr;

  assign accept_evt = ev_valid & ~port_busy;
  assign drop_evt   = ev_valid & port_busy & rt_mode;
  assign cpu_stall  = ev_valid & port_busy & ~rt_mode;

  trc_hist u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(accept_evt), .kind(ev_kind),
    .wr_addr(ev_addr), .prev_addr(prev_addr), .prev_seen(prev_seen)
  );

  assign code = len_code(ev_addr, prev_addr, prev_seen);
  assign hdr  = {ev_kind, 1'b0, code};

  trc_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .hdr(hdr),
    .payload(ev_addr), .nibs(code_nibbles(code)),
    .data(tp_data), .sync_n(tp_sync_n), .busy(port_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         lost_flag <= 1'b0;
    else if (drop_evt)  lost_flag <= 1'b1;
    else if (lost_clr)  lost_flag <= 1'b0;
  end
endmodule

// File: rtl/trc_delta_packer_chk.sv
module trc_delta_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rt_mode,
  input logic       lost_clr,
  input logic [3:0] tp_data,
  input logic       tp_sync_n,
  input logic       cpu_stall,
  input logic       lost_flag,
  input logic       accept_evt,
  input logic       drop_evt,
  input logic       port_busy
);
  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_sync_n |=> tp_sync_n);
  assert_hdr_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_sync_n |-> tp_data[2] == 1'b0);
  assert_accept_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !tp_sync_n && port_busy);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !port_busy |-> tp_sync_n && tp_data == 4'd0);
  assert_rt_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rt_mode |-> !cpu_stall);
  assert_drop_sets_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> lost_flag);
  assert_clear_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_clr && !drop_evt) |=> !lost_flag);
  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> port_busy && !accept_evt);
endmodule

bind trc_delta_packer trc_delta_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rt_mode(rt_mode), .lost_clr(lost_clr),
  .tp_data(tp_data), .tp_sync_n(tp_sync_n), .cpu_stall(cpu_stall),
  .lost_flag(lost_flag), .accept_evt(accept_evt), .drop_evt(drop_evt),
  .port_busy(port_busy)
);

// File: tb/trc_delta_packer_test.sv
`timescale 1ns/1ps
module trc_delta_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_addr = '0;
  logic        ev_kind = 1'b0;
  logic        rt_mode = 1'b1;
  logic        lost_clr = 1'b0;
  logic [3:0]  tp_data;
  logic        tp_sync_n, cpu_stall, lost_flag;

  int checks = 0, errors = 0, cycles = 0;

  trc_delta_packer uut (.*);

  always #2.5 clk = ~clk;

  // receiver: rebuilds messages from the port
  logic [31:0] msg_pay  [0:511];
  int          msg_len  [0:511];
  logic        msg_kind [0:511];
  int msg_cnt = 0, rx_left = 0, rx_pos = 0, rd_idx = 0;
  logic [31:0] rx_pay;
  logic        rx_kind;

  logic [31:0] hist [2];
  logic        seen [2];

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_left > 0) begin
        chk(tp_sync_n, "R3 sync high in payload", tp_sync_n, 1);
        rx_pay[rx_pos*4 +: 4] = tp_data;
        rx_pos++;
        rx_left--;
        if (rx_left == 0) begin
          msg_pay[msg_cnt]  = rx_pay;
          msg_len[msg_cnt]  = rx_pos;
          msg_kind[msg_cnt] = rx_kind;
          msg_cnt++;
        end
      end else if (!tp_sync_n) begin
        chk(tp_data[2] == 1'b0, "R2 header bit2", tp_data[2], 0);
        rx_kind = tp_data[3];
        rx_left = 1 << tp_data[1:0];
        rx_pos  = 0;
        rx_pay  = '0;
      end else begin
        chk(tp_data == 4'd0, "R3 idle data", tp_data, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected length from the highest differing bit
  function automatic int exp_nibs(input logic [31:0] a, input logic [31:0] p, input logic s);
    int msb = -1;
    if (!s) return 8;
    for (int i = 0; i < 32; i++) if (a[i] != p[i]) msb = i;
    if (msb < 4)  return 1;
    if (msb < 8)  return 2;
    if (msb < 16) return 4;
    return 8;
  endfunction

  task automatic put_event(input logic k, input logic [31:0] a, output int stalls);
    ev_kind = k; ev_addr = a; ev_valid = 1'b1; stalls = 0;
    #1;
    while (cpu_stall) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic k, input logic [31:0] a, input string tag);
    int w = 0;
    int n;
    logic [31:0] mask, rec;
    while (msg_cnt <= rd_idx && w < 60) begin @(negedge clk); w++; end
    chk(msg_cnt > rd_idx, {tag, " message present"}, msg_cnt, rd_idx + 1);
    if (msg_cnt > rd_idx) begin
      n = exp_nibs(a, hist[k], seen[k]);
      chk(msg_kind[rd_idx] == k, {tag, " kind"}, msg_kind[rd_idx], k);
      chk(msg_len[rd_idx] == n, {tag, " length"}, msg_len[rd_idx], n);
      mask = (msg_len[rd_idx] >= 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*msg_len[rd_idx])) - 1);
      rec  = (hist[k] & ~mask) | (msg_pay[rd_idx] & mask);
      chk(rec == a, {tag, " rebuilt address"}, rec, a);
      rd_idx++;
    end
    hist[k] = a; seen[k] = 1'b1;
  endtask

  task automatic send(input logic k, input logic [31:0] a, input string tag);
    int st;
    put_event(k, a, st);
    expect_msg(k, a, tag);
    @(negedge clk);
  endtask

  initial begin
    int st;
    logic [31:0] a, b;
    hist[0] = '0; hist[1] = '0; seen[0] = 1'b0; seen[1] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tp_sync_n == 1 && tp_data == 0, "R1 port idle in reset", {tp_sync_n, tp_data}, 5'h10);
    chk(!cpu_stall && !lost_flag, "R1 stall/lost clear", {cpu_stall, lost_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tp_sync_n && !cpu_stall && !lost_flag, "R1 after reset", {tp_sync_n, cpu_stall, lost_flag}, 3'b100);

    // R5 / R6: first message per kind is full; histories separate
    send(1'b0, 32'h1234_5678, "R5 first branch");
    send(1'b1, 32'h1234_5679, "R6 first window");
    send(1'b0, 32'h1234_567A, "R6 branch own history");
    send(1'b1, 32'h1234_5000, "R6 window own history");

    // R4 sweep of every single differing bit, both kinds
    for (int k = 0; k < 2; k++)
      for (int bt = 0; bt < 32; bt++)
        send(k[0], hist[k] ^ (32'h1 << bt), "R4 bit sweep");

    // R4 random addresses
    for (int i = 0; i < 30; i++) begin
      a = $urandom;
      a = (i % 4 == 0) ? a : (hist[i%2] ^ (a >> (4 * (i % 8))));
      send(i[0], a, "R4 random");
    end

    // R10 busy window, R9 stall in non-realtime mode
    rt_mode = 1'b0;
    a = hist[0] ^ 32'h8000_0000;
    b = a ^ 32'h0000_0003;
    ev_kind = 1'b0; ev_addr = a; ev_valid = 1'b1;
    @(negedge clk);
    put_event(1'b0, b, st);
    chk(st == 9, "R9 stall cycles behind 8-nibble message", st, 9);
    expect_msg(1'b0, a, "R10 first of pair");
    expect_msg(1'b0, b, "R9 held event sent");
    @(negedge clk);
    #1 chk(!cpu_stall, "R9 stall released", cpu_stall, 0);

    // R7 realtime drop, R11 history unaffected
    rt_mode = 1'b1;
    a = hist[0] ^ 32'h8000_0000;
    ev_kind = 1'b0; ev_addr = a; ev_valid = 1'b1;
    @(negedge clk);
    ev_addr = a ^ 32'h0F00_0000;
    #1 chk(!cpu_stall, "R7 no stall in realtime", cpu_stall, 0);
    @(negedge clk);
    ev_valid = 1'b0;
    chk(lost_flag, "R7 lost set on drop", lost_flag, 1);
    expect_msg(1'b0, a, "R7 message in flight completes");
    repeat (15) @(negedge clk);
    chk(msg_cnt == rd_idx, "R7 dropped event not sent", msg_cnt, rd_idx);
    send(1'b0, a ^ 32'h0000_0010, "R11 history after drop");

    // R8 clear, then drop and clear in the same cycle
    lost_clr = 1'b1;
    @(negedge clk);
    lost_clr = 1'b0;
    chk(!lost_flag, "R8 lost cleared", lost_flag, 0);
    a = hist[1] ^ 32'h0001_0000;
    ev_kind = 1'b1; ev_addr = a; ev_valid = 1'b1;
    @(negedge clk);
    ev_addr = 32'hDEAD_BEEF; lost_clr = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; lost_clr = 1'b0;
    chk(lost_flag, "R8 drop wins over clear", lost_flag, 1);
    expect_msg(1'b1, a, "R8 window message");
    lost_clr = 1'b1;
    @(negedge clk);
    lost_clr = 1'b0;
    chk(!lost_flag, "R8 final clear", lost_flag, 0);

    repeat (5) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule